// File: doc/BRIEF.md
# Two-Thread Back-End Resource Allocator

This block sits between two per-thread micro-op queues and the out-of-order back end. Each cycle it picks one thread's queue head and reserves, all at once, every back-end resource that micro-op asks for. The resource kinds are a reorder-buffer slot, a physical register, a load-buffer slot and a store-buffer slot. Every pool is split in half between the two threads. A thread can never hold more than its half, so one thread cannot starve the other or lock up the machine. On success the block returns the slot index from each pool used. On failure the thread is marked stalled and nothing is reserved.

Selection alternates between the threads on successive cycles while both can be served. When one thread is halted, has no micro-op, or cannot fit its micro-op, the other thread is served on every cycle. A configuration input lets a lone running thread use whole pools while its partner is halted. Retirement returns resources through a release pulse. The pulse names a thread and carries a mask of resource kinds, and it frees one slot of each kind named. A release that finds a counter already at zero leaves the counter alone and raises a per-kind error pulse.

Top module: `ht_res_alloc`

## Requirements
- R1: After reset every occupancy is zero, `uop_ready`, `uop_stall`, `alloc_valid` and `rel_err` are low, and the first cycle in which both threads are eligible goes to thread 0.
- R2: When both threads are eligible in consecutive cycles, the grant goes to the thread that was not served last time, and at most one thread is granted per cycle.
- R3: A halted thread (`thr_halt[t]`=1) or a thread without a valid micro-op is never granted, and the other thread is then granted on every cycle in which it fits.
- R4: In split mode a thread holds at most half of each pool (ROB 63, registers 64, loads 24, stores 12). A micro-op needing a kind that is full for its thread raises `uop_stall[t]`, and `uop_ready[t]` stays low. The other thread is unaffected.
- R5: Allocation is all or nothing. If any needed kind lacks room, no pool of that thread is touched, and its next successful index in every other pool continues without a gap.
- R6: Need and release masks use bit 0 for ROB, bit 1 for register, bit 2 for load and bit 3 for store. The index for thread t in a pool of size S is (t*S/2 + p) mod S. Here p is the thread's allocation count in that pool, which wraps at its cap, so that in split mode thread 1 starts at S/2 and wraps back to S/2.
- R7: A release pulse (`rel_valid`, `rel_tid`, `rel_mask`) lowers each named kind's occupancy of that thread by one. The freed room can be granted on the next cycle.
- R8: A release naming a kind whose occupancy is zero leaves that counter unchanged and drives the matching `rel_err` bit high for exactly the following cycle.
- R9: With `solo_cfg`=1 and the partner halted, the running thread's cap becomes the full pool size, and its indices run past the half boundary and wrap modulo the pool size.
- R10: `uop_ready`, `uop_stall` and the allocation outputs are combinational in the cycle of the request. Occupancy changes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uop_valid | input | 2 | Per-thread queue head is valid |
| uop0_need | input | 4 | Resource kinds needed by thread 0's head |
| uop1_need | input | 4 | Resource kinds needed by thread 1's head |
| thr_halt | input | 2 | Per-thread halted flag |
| solo_cfg | input | 1 | Allow a lone thread to use whole pools |
| rel_valid | input | 1 | Release pulse from retirement |
| rel_tid | input | 1 | Thread owning the released resources |
| rel_mask | input | 4 | Resource kinds released, one slot each |
| uop_ready | output | 2 | One-hot grant, the head is consumed this cycle |
| uop_stall | output | 2 | Thread is requesting but does not fit |
| alloc_valid | output | 1 | An allocation happens this cycle |
| alloc_tid | output | 1 | Thread that received the allocation |
| alloc_rob_idx | output | 7 | Reorder-buffer slot |
| alloc_reg_idx | output | 7 | Physical register |
| alloc_ld_idx | output | 7 | Load-buffer slot (upper bits zero) |
| alloc_st_idx | output | 7 | Store-buffer slot (upper bits zero) |
| rel_err | output | 4 | Per-kind release-underflow pulse |

## Verification
The bench fills thread 0's store share until its cap and checks two things: the stall appears exactly on the thirteenth request, and thread 1 keeps flowing. A cap that is off by one would grant once more or stall one micro-op early. A micro-op that needs a full kind alongside free ones is then retried on the free kinds only. A design that reserved part of the set before failing would show a gap in the register index. The store pointer of thread 1 is driven around its partition with overlapping allocate and release, which exposes a wrap at the wrong boundary or a lost count when both happen in one cycle. Releases at zero occupancy must pulse the error bit for the right kind without wrapping the counter. Solo mode must let indices cross the half boundary and still stop at the full pool size.

// File: rtl/ht_alloc_pkg.sv
// Package: shared constants and the resource-kind numbering used on the
// need and release masks. Assumes exactly two hardware threads.
package ht_alloc_pkg;
    localparam int NUM_THR   = 2;
    localparam int NUM_POOLS = 4;

    // Bit position of each resource kind in need/release masks.
    typedef enum int {
        POOL_ROB = 0,
        POOL_REG = 1,
        POOL_LD  = 2,
        POOL_ST  = 3
    } pool_e;
endpackage

// File: rtl/ht_alloc_pool.sv
// Module: occupancy and index bookkeeping for one resource pool shared by
// two threads. Each thread owns a ring of slots starting at t*SIZE/2; its cap
// is SIZE/2, or SIZE when solo[t] is set. Assumes solo mode only changes while
// the partner holds nothing of this pool, and that release order matches
// allocation order (retirement is in program order).
module ht_alloc_pool #(
    parameter int SIZE  = 126,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       solo,
    input  logic [1:0]       need,
    input  logic             alloc_en,
    input  logic             alloc_tid,
    input  logic             rel_en,
    input  logic             rel_tid,
    output logic [1:0]       room,
    output logic [IDX_W-1:0] idx,
    output logic             err
);
    localparam int HALF = SIZE / 2;
    localparam int CW   = $clog2(SIZE + 1);

    logic [CW-1:0] cnt_q [2];
    logic [CW-1:0] ptr_q [2];
    logic [CW-1:0] cap   [2];
    logic [1:0]    inc;
    logic [1:0]    dec;
    logic [CW:0]   raw_sum;
    logic [CW:0]   slot;
    logic          err_q;

    // Per-thread cap, room check and counter step enables.
    always_comb begin
        for (int t = 0; t < 2; t++) begin
            cap[t]  = solo[t] ? CW'(SIZE) : CW'(HALF);
            room[t] = !need[t] || (cnt_q[t] < cap[t]);
            inc[t]  = alloc_en && (alloc_tid == 1'(t));
            dec[t]  = rel_en && (rel_tid == 1'(t)) && (cnt_q[t] != '0);
        end
    end

    // Slot index of the allocating thread: partition base plus ring position.
    always_comb begin
        raw_sum = {1'b0, ptr_q[alloc_tid]} + (alloc_tid ? (CW+1)'(HALF) : '0);
        slot    = (raw_sum >= (CW+1)'(SIZE)) ? raw_sum - (CW+1)'(SIZE) : raw_sum;
        idx     = IDX_W'(slot);
    end

    // Occupancy counters, ring pointers and the underflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 2; t++) begin
                cnt_q[t] <= '0;
                ptr_q[t] <= '0;
            end
            err_q <= 1'b0;
        end else begin
            for (int t = 0; t < 2; t++) begin
                cnt_q[t] <= cnt_q[t] + CW'(inc[t]) - CW'(dec[t]);
                if (inc[t]) begin
                    ptr_q[t] <= (ptr_q[t] == cap[t] - 1'b1) ? '0 : ptr_q[t] + 1'b1;
                end
            end
            err_q <= rel_en && (cnt_q[rel_tid] == '0);
        end
    end

    assign err = err_q;

    // Checks per thread on counter movement.
    for (genvar t = 0; t < 2; t++) begin : g_chk
        assert_alloc_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_en && alloc_tid == 1'(t)) |-> (cnt_q[t] < cap[t]));
        assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_en && rel_tid == 1'(t) && cnt_q[t] != '0 && !(alloc_en && alloc_tid == 1'(t)))
            |=> (cnt_q[t] == $past(cnt_q[t]) - 1'b1));
        assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_en && rel_tid == 1'(t) && cnt_q[t] == '0) |=> (err && cnt_q[t] == $past(cnt_q[t])));
    end

    assert_pool_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q[0]} + {1'b0, cnt_q[1]}) <= (CW+1)'(SIZE));
endmodule

// File: rtl/ht_alloc_arb.sv
// Module: two-thread selector. Grants one eligible thread per cycle,
// alternating while both are eligible; a lone eligible thread is served every
// cycle. Assumes req already excludes halted threads.
module ht_alloc_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic [1:0] fit,
    output logic [1:0] grant,
    output logic       sel,
    output logic [1:0] stall
);
    logic [1:0] elig;
    logic       last_q;

    // Grant selection from eligibility and the last-served thread.
    always_comb begin
        elig  = req & fit;
        stall = req & ~fit;
        if (elig == 2'b11) begin
            grant = last_q ? 2'b01 : 2'b10;
        end else begin
            grant = elig;
        end
        sel = grant[1];
    end

    // Remember the thread served most recently; reset favours thread 0 next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else if (grant != 2'b00) begin
            last_q <= grant[1];
        end
    end

    assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_alternate_t0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b11 && $past(rst_n) && $past(grant) == 2'b01) |-> (grant == 2'b10));
    assert_alternate_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b11 && $past(rst_n) && $past(grant) == 2'b10) |-> (grant == 2'b01));
endmodule

// File: rtl/ht_res_alloc.sv
// Module: top of the two-thread resource allocator. Combines one pool
// instance per resource kind with the thread selector; a thread fits only if
// every kind it needs has room in its share. Assumes the need masks are
// stable while uop_valid is held and solo_cfg changes only when idle.
module ht_res_alloc #(
    parameter int ROB_SIZE = 126,
    parameter int REG_SIZE = 128,
    parameter int LD_SIZE  = 48,
    parameter int ST_SIZE  = 24,
    parameter int IDX_W    = $clog2(ROB_SIZE > REG_SIZE ? ROB_SIZE : REG_SIZE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       uop_valid,
    input  logic [3:0]       uop0_need,
    input  logic [3:0]       uop1_need,
    input  logic [1:0]       thr_halt,
    input  logic             solo_cfg,
    input  logic             rel_valid,
    input  logic             rel_tid,
    input  logic [3:0]       rel_mask,
    output logic [1:0]       uop_ready,
    output logic [1:0]       uop_stall,
    output logic             alloc_valid,
    output logic             alloc_tid,
    output logic [IDX_W-1:0] alloc_rob_idx,
    output logic [IDX_W-1:0] alloc_reg_idx,
    output logic [IDX_W-1:0] alloc_ld_idx,
    output logic [IDX_W-1:0] alloc_st_idx,
    output logic [3:0]       rel_err
);
    import ht_alloc_pkg::*;

    function automatic int pool_size(input int k);
        case (k)
            POOL_ROB: return ROB_SIZE;
            POOL_REG: return REG_SIZE;
            POOL_LD:  return LD_SIZE;
            default:  return ST_SIZE;
        endcase
    endfunction

    logic [1:0]       req;
    logic [1:0]       fit;
    logic [1:0]       grant;
    logic             sel;
    logic [1:0]       solo;
    logic [3:0]       sel_need;
    logic [1:0]       room_all [NUM_POOLS];
    logic [IDX_W-1:0] idx_all  [NUM_POOLS];

    // Request and solo qualification per thread.
    always_comb begin
        req     = uop_valid & ~thr_halt;
        solo[0] = solo_cfg && thr_halt[1];
        solo[1] = solo_cfg && thr_halt[0];
    end

    // A thread fits only when all needed kinds have room.
    always_comb begin
        fit = 2'b11;
        for (int k = 0; k < NUM_POOLS; k++) begin
            fit = fit & room_all[k];
        end
    end

    ht_alloc_arb arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .fit   (fit),
        .grant (grant),
        .sel   (sel),
        .stall (uop_stall)
    );

    assign sel_need = sel ? uop1_need : uop0_need;

    for (genvar k = 0; k < NUM_POOLS; k++) begin : g_pool
        ht_alloc_pool #(
            .SIZE  (pool_size(k)),
            .IDX_W (IDX_W)
        ) pool_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .solo      (solo),
            .need      ({uop1_need[k], uop0_need[k]}),
            .alloc_en  ((grant != 2'b00) && sel_need[k]),
            .alloc_tid (sel),
            .rel_en    (rel_valid && rel_mask[k]),
            .rel_tid   (rel_tid),
            .room      (room_all[k]),
            .idx       (idx_all[k]),
            .err       (rel_err[k])
        );
    end

    // Drive the allocation result ports.
    always_comb begin
        uop_ready     = grant;
        alloc_valid   = (grant != 2'b00);
        alloc_tid     = sel;
        alloc_rob_idx = idx_all[POOL_ROB];
        alloc_reg_idx = idx_all[POOL_REG];
        alloc_ld_idx  = idx_all[POOL_LD];
        alloc_st_idx  = idx_all[POOL_ST];
    end

    assert_halt_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_ready & thr_halt) == 2'b00);
    assert_stall_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_ready & uop_stall) == 2'b00);
endmodule

// File: tb/ht_res_alloc_tb_top.sv
`timescale 1ns/1ps
module ht_res_alloc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] uop_valid = '0;
    logic [3:0] uop0_need = '0;
    logic [3:0] uop1_need = '0;
    logic [1:0] thr_halt = '0;
    logic       solo_cfg = 1'b0;
    logic       rel_valid = 1'b0;
    logic       rel_tid = 1'b0;
    logic [3:0] rel_mask = '0;
    logic [1:0] uop_ready, uop_stall;
    logic       alloc_valid, alloc_tid;
    logic [6:0] alloc_rob_idx, alloc_reg_idx, alloc_ld_idx, alloc_st_idx;
    logic [3:0] rel_err;

    always #2.5 clk = ~clk;

    ht_res_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop0_need(uop0_need),
        .uop1_need(uop1_need), .thr_halt(thr_halt), .solo_cfg(solo_cfg),
        .rel_valid(rel_valid), .rel_tid(rel_tid), .rel_mask(rel_mask),
        .uop_ready(uop_ready), .uop_stall(uop_stall), .alloc_valid(alloc_valid),
        .alloc_tid(alloc_tid), .alloc_rob_idx(alloc_rob_idx), .alloc_reg_idx(alloc_reg_idx),
        .alloc_ld_idx(alloc_ld_idx), .alloc_st_idx(alloc_st_idx), .rel_err(rel_err)
    );

    typedef struct packed {
        logic [1:0]      rdy;
        logic [1:0]      stl;
        logic            av;
        logic            tid;
        logic [3:0]      need;
        logic [3:0]      err;
        logic [3:0][6:0] idx;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    // Reference state derived from the requirements.
    int m_cnt [2][4];
    int m_ptr [2][4];
    int m_size [4] = '{126, 128, 48, 24};
    bit m_last = 1'b1;
    bit [3:0] m_err = '0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected outputs.
    task automatic step(input bit v0, input bit v1, input bit h0, input bit h1,
                        input bit [3:0] n0, input bit [3:0] n1, input bit solo,
                        input bit rv, input bit rt, input bit [3:0] rm, input string tag);
        bit [1:0] v, h, req, fit, elig, gnt;
        bit [3:0] need [2];
        bit [3:0] new_err;
        int cap [2][4];
        exp_t e;
        @(posedge clk);
        #1;
        uop_valid = {v1, v0}; thr_halt = {h1, h0};
        uop0_need = n0; uop1_need = n1; solo_cfg = solo;
        rel_valid = rv; rel_tid = rt; rel_mask = rm;
        v = {v1, v0}; h = {h1, h0}; need[0] = n0; need[1] = n1;
        for (int t = 0; t < 2; t++) begin
            fit[t] = 1'b1;
            for (int p = 0; p < 4; p++) begin
                cap[t][p] = (solo && h[1-t]) ? m_size[p] : m_size[p] / 2;
                if (need[t][p] && m_cnt[t][p] >= cap[t][p]) fit[t] = 1'b0;
            end
        end
        req  = v & ~h;
        elig = req & fit;
        if (elig == 2'b11) gnt = m_last ? 2'b01 : 2'b10;
        else gnt = elig;
        e = '0;
        e.rdy = gnt; e.stl = req & ~fit; e.av = (gnt != 0); e.tid = gnt[1];
        e.err = m_err;
        if (e.av) begin
            e.need = need[e.tid];
            for (int p = 0; p < 4; p++)
                e.idx[p] = 7'((e.tid * (m_size[p] / 2) + m_ptr[e.tid][p]) % m_size[p]);
        end
        sb_q.push_back(e);
        tag_q.push_back(tag);
        new_err = '0;
        for (int p = 0; p < 4; p++) begin
            if (rv && rm[p]) begin
                if (m_cnt[rt][p] == 0) new_err[p] = 1'b1;
                else m_cnt[rt][p]--;
            end
        end
        if (e.av) begin
            m_last = e.tid;
            for (int p = 0; p < 4; p++) begin
                if (e.need[p]) begin
                    m_cnt[e.tid][p]++;
                    m_ptr[e.tid][p] = (m_ptr[e.tid][p] == cap[e.tid][p] - 1) ? 0 : m_ptr[e.tid][p] + 1;
                end
            end
        end
        m_err = new_err;
    endtask

    // Monitor: pops each expected cycle and compares at the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t  e;
            string tg;
            e  = sb_q.pop_front();
            tg = tag_q.pop_front();
            chk(tg, "ready", int'(uop_ready), int'(e.rdy));
            chk(tg, "stall", int'(uop_stall), int'(e.stl));
            chk(tg, "alloc_valid", int'(alloc_valid), int'(e.av));
            chk(tg, "rel_err", int'(rel_err), int'(e.err));
            if (e.av) begin
                chk(tg, "tid", int'(alloc_tid), int'(e.tid));
                if (e.need[0]) chk(tg, "rob_idx", int'(alloc_rob_idx), int'(e.idx[0]));
                if (e.need[1]) chk(tg, "reg_idx", int'(alloc_reg_idx), int'(e.idx[1]));
                if (e.need[2]) chk(tg, "ld_idx",  int'(alloc_ld_idx),  int'(e.idx[2]));
                if (e.need[3]) chk(tg, "st_idx",  int'(alloc_st_idx),  int'(e.idx[3]));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: idle after reset, then first contested grant to thread 0.
        step(0,0,0,0, 4'b0000,4'b0000, 0, 0,0,4'b0000, "R1");
        step(0,0,0,0, 4'b0000,4'b0000, 0, 0,0,4'b0000, "R1");
        step(1,1,0,0, 4'b0001,4'b0001, 0, 0,0,4'b0000, "R1");
        // R2: alternation with both eligible.
        for (int i = 0; i < 6; i++) step(1,1,0,0, 4'b0001,4'b0011, 0, 0,0,4'b0000, "R2");
        // R3: halted or idle partner.
        for (int i = 0; i < 4; i++) step(1,1,0,1, 4'b0001,4'b0001, 0, 0,0,4'b0000, "R3");
        for (int i = 0; i < 3; i++) step(0,1,0,0, 4'b0001,4'b0001, 0, 0,0,4'b0000, "R3");
        // R4: thread 0 fills its store share and stalls; thread 1 keeps going.
        for (int i = 0; i < 28; i++) step(1,1,0,0, 4'b1001,4'b0001, 0, 0,0,4'b0000, "R4");
        // R5: all-or-nothing, then the free kinds alone without a gap.
        for (int i = 0; i < 2; i++) step(1,1,0,0, 4'b1011,4'b0001, 0, 0,0,4'b0000, "R5");
        for (int i = 0; i < 2; i++) step(1,0,0,0, 4'b0011,4'b0001, 0, 0,0,4'b0000, "R5");
        // R7: a store release lets thread 0 store again next cycle.
        step(0,0,0,0, 4'b0000,4'b0000, 0, 1,0,4'b1000, "R7");
        step(1,0,0,0, 4'b1001,4'b0000, 0, 0,0,4'b0000, "R7");
        step(1,0,0,0, 4'b1001,4'b0000, 0, 1,0,4'b1001, "R7");
        step(1,0,0,0, 4'b1001,4'b0000, 0, 0,0,4'b0000, "R7");
        // R8: release with nothing held raises the load error bit.
        step(0,0,0,0, 4'b0000,4'b0000, 0, 1,1,4'b0100, "R8");
        step(0,0,0,0, 4'b0000,4'b0000, 0, 0,0,4'b0000, "R8");
        step(0,0,0,0, 4'b0000,4'b0000, 0, 0,0,4'b0000, "R8");
        // R6: thread 1 store ring wraps inside its partition.
        step(0,1,0,0, 4'b0000,4'b1000, 0, 0,0,4'b0000, "R6");
        for (int i = 0; i < 30; i++) step(0,1,0,0, 4'b0000,4'b1000, 0, 1,1,4'b1000, "R6");
        // R9: solo mode lets thread 0 take the whole load buffer.
        for (int i = 0; i < 52; i++) step(1,0,0,1, 4'b0100,4'b0000, 1, 0,0,4'b0000, "R9");
        // R10: flush the pipeline of expectations.
        step(0,0,0,0, 4'b0000,4'b0000, 0, 0,0,4'b0000, "R10");
        step(0,0,0,0, 4'b0000,4'b0000, 0, 0,0,4'b0000, "R10");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule